// File: doc/BRIEF.md
# Dual Receive Buffer Controller

This block sits between a byte-wide receive stream and a register bus. Each frame that arrives on the stream (one byte per cycle while `rx_valid` is high, the final byte flagged by `rx_last`) is written into one of two receive buffers in a memory window. The two buffers are used in strict turn, and the first frame after reset goes to the first buffer. When the final byte has been stored, the block sets the buffer's done flag. If software has enabled it, the block also raises an interrupt.

Software reads the stored frame and the status word over the bus. It then writes the status word with the done bit at zero, and the buffer becomes free again. If the buffer whose turn it is still has its done flag set when a new frame begins, the whole frame is thrown away and a drop counter advances. A parameter can remove the second buffer. Every frame then lands in the first buffer.

Top module: `rx_pingpong_buf`

## Requirements
- R1: After reset both done flags and both interrupt-enable bits are 0, `irq` is 0, `drop_count` is 0, and the first frame is written to buffer 0.
- R2: Byte address 0x1000 is the base of buffer 0 and 0x1800 is the base of buffer 1. Each buffer's status word sits at base + 0x7FC and reads bit 0 = done, bit 3 = interrupt enable, with all other bits 0. Reads below 0x1000 return 0.
- R3: Frame byte n is stored at buffer base + n. Four bytes share a 32-bit word, with byte 0 in bits 7:0. As a result the two-byte type/length field (frame bytes 12 and 13) reads in bits 15:0 of the word at base + 12.
- R4: The done flag of the target buffer is set by the clock edge that accepts the frame's final byte. Read data is returned on the cycle after the read request.
- R5: Accepted frames alternate between buffer 0 and buffer 1.
- R6: A status write with bit 0 = 0 clears done, and a write with bit 0 = 1 leaves done unchanged. Bit 3 of every status write loads the interrupt-enable bit.
- R7: `irq` is high exactly when `irq_global_en` is high and some buffer has both done and interrupt enable set.
- R8: If the buffer whose turn it is has done set when a frame's first byte arrives, no byte of that frame is written, `drop_count` increases by one, and the turn does not advance.
- R9: A frame longer than 2044 bytes keeps its first 2044 bytes. The rest are discarded without wrapping, and done is still set at the final byte.
- R10: With `DUAL_BUF` = 0 every frame goes to buffer 0, and the buffer 1 window and status read as 0.
- R11: The done flag seen at the start of a frame is the value registered before that edge. A status clear in the same cycle as a frame's first byte therefore does not save that frame from being dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Marks the final byte of a frame |
| bus_addr | input | ADDR_W | Byte address of the bus access |
| bus_wr | input | 1 | Bus write strobe |
| bus_wdata | input | 32 | Bus write data |
| bus_rd | input | 1 | Bus read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq_global_en | input | 1 | Global interrupt enable |
| irq | output | 1 | Receive interrupt |
| drop_count | output | DROP_W | Count of frames discarded for lack of a free buffer (wraps) |

## Verification
Two functions can coincide on one clock edge: the drop-or-store decision at the first byte of a frame, and a software status write that clears the done flag of that same buffer. The bench starts a frame and the clearing write in parallel, so both land on the same edge. It then judges the outcome from the ports. The drop counter must have advanced, the buffer's old contents must survive, the status must read as cleared, and the following frame must land in that buffer. A second instance built without the second buffer is checked for single-buffer placement.

// File: rtl/rxpp_pkg.sv
package rxpp_pkg;
  typedef enum logic [1:0] {
    WR_IDLE  = 2'd0,
    WR_STORE = 2'd1,
    WR_SKIP  = 2'd2
  } rxw_state_e;

  localparam int STAT_DONE_BIT = 0;
  localparam int STAT_IE_BIT   = 3;
endpackage

// File: rtl/rxpp_ram.sv
module rxpp_ram #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [1:0]    wlane,
  input  logic [7:0]    wbyte,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar ln = 0; ln < 4; ln++) begin : g_lane
    logic [7:0] mem [DEPTH];
    logic [7:0] rd_q;

    always_ff @(posedge clk) begin
      if (we && (wlane == 2'(ln))) begin
        mem[waddr] <= wbyte;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rd_q <= '0;
      end else if (re) begin
        rd_q <= mem[raddr];
      end
    end

    assign rdata[8*ln +: 8] = rd_q;
  end
endmodule

// File: rtl/rxpp_writer.sv
module rxpp_writer
  import rxpp_pkg::*;
#(
  parameter int DUAL_BUF = 1,
  parameter int BUF_AW   = 11,
  parameter int DROP_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  input  logic [1:0]        done_q,
  output logic              mem_we,
  output logic              mem_buf,
  output logic [BUF_AW-1:0] mem_byte,
  output logic [7:0]        mem_data,
  output logic [1:0]        done_set,
  output logic [DROP_W-1:0] drop_count
);
  localparam logic [BUF_AW-1:0] DATA_BYTES = BUF_AW'((1 << BUF_AW) - 4);

  rxw_state_e        state_q, state_d;
  logic              cur_q, cur_d;
  logic [BUF_AW-1:0] ofs_q, ofs_d;
  logic [DROP_W-1:0] drop_q, drop_d;
  logic              store;
  logic [BUF_AW-1:0] idx;

  always_comb begin
    state_d  = state_q;
    cur_d    = cur_q;
    ofs_d    = ofs_q;
    drop_d   = drop_q;
    store    = 1'b0;
    idx      = ofs_q;
    done_set = '0;
    case (state_q)
      WR_IDLE: begin
        if (rx_valid) begin
          idx = '0;
          if (done_q[cur_q]) begin
            drop_d = drop_q + 1'b1;
            if (!rx_last) state_d = WR_SKIP;
          end else begin
            store = 1'b1;
            ofs_d = BUF_AW'(1);
            if (!rx_last) state_d = WR_STORE;
          end
        end
      end
      WR_STORE: begin
        if (rx_valid) begin
          store = 1'b1;
          if (ofs_q != DATA_BYTES) ofs_d = ofs_q + 1'b1;
          if (rx_last) state_d = WR_IDLE;
        end
      end
      WR_SKIP: begin
        if (rx_valid && rx_last) state_d = WR_IDLE;
      end
      default: state_d = WR_IDLE;
    endcase
    if (store && rx_last) begin
      done_set[cur_q] = 1'b1;
      if (DUAL_BUF != 0) cur_d = ~cur_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WR_IDLE;
      cur_q   <= 1'b0;
      ofs_q   <= '0;
      drop_q  <= '0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      ofs_q   <= ofs_d;
      drop_q  <= drop_d;
    end
  end

  assign mem_we     = store && (idx != DATA_BYTES);
  assign mem_buf    = cur_q;
  assign mem_byte   = idx;
  assign mem_data   = rx_data;
  assign drop_count = drop_q;
endmodule

// File: rtl/rxpp_status.sv
module rxpp_status #(
  parameter int NBUF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] done_set,
  input  logic       wr_en,
  input  logic       wr_buf,
  input  logic       wr_done,
  input  logic       wr_ie,
  input  logic       gie,
  output logic [1:0] done_q,
  output logic [1:0] ie_q,
  output logic       irq
);
  for (genvar b = 0; b < 2; b++) begin : g_buf
    if (b < NBUF) begin : g_on
      logic done_d, ie_d, hit;
      always_comb begin
        hit    = wr_en && (wr_buf == 1'(b));
        done_d = done_q[b];
        ie_d   = ie_q[b];
        if (hit) begin
          ie_d = wr_ie;
          if (!wr_done) done_d = 1'b0;
        end
        if (done_set[b]) done_d = 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          done_q[b] <= 1'b0;
          ie_q[b]   <= 1'b0;
        end else begin
          done_q[b] <= done_d;
          ie_q[b]   <= ie_d;
        end
      end
    end else begin : g_off
      assign done_q[b] = 1'b0;
      assign ie_q[b]   = 1'b0;
    end
  end

  assign irq = gie && (|(done_q & ie_q));
endmodule

// File: rtl/rx_pingpong_buf.sv
module rx_pingpong_buf
  import rxpp_pkg::*;
#(
  parameter int DUAL_BUF = 1,
  parameter int BUF_AW   = 11,
  parameter int DROP_W   = 8,
  localparam int ADDR_W  = BUF_AW + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  input  logic              irq_global_en,
  output logic              irq,
  output logic [DROP_W-1:0] drop_count
);
  localparam int NBUF    = (DUAL_BUF != 0) ? 2 : 1;
  localparam int WORD_AW = BUF_AW - 2;
  localparam int RAM_AW  = WORD_AW + NBUF - 1;
  localparam logic [WORD_AW-1:0] STAT_WORD = '1;

  logic               a_buf, buf_ok, is_stat, stat_wr;
  logic [WORD_AW-1:0] a_word;
  logic [1:0]         done_q, ie_q, done_set;
  logic               mem_we, mem_buf;
  logic [BUF_AW-1:0]  mem_byte;
  logic [7:0]         mem_data;
  logic [31:0]        ram_rdata, stat_val;
  logic               rd_hit_q, rd_stat_q;
  logic [31:0]        rd_stat_val_q;

  assign a_buf   = bus_addr[BUF_AW];
  assign a_word  = bus_addr[BUF_AW-1:2];
  assign buf_ok  = bus_addr[ADDR_W-1] && ((DUAL_BUF != 0) || !a_buf);
  assign is_stat = (a_word == STAT_WORD);
  assign stat_wr = bus_wr && buf_ok && is_stat;

  always_comb begin
    stat_val = '0;
    stat_val[STAT_DONE_BIT] = done_q[a_buf];
    stat_val[STAT_IE_BIT]   = ie_q[a_buf];
  end

  rxpp_writer #(.DUAL_BUF(DUAL_BUF), .BUF_AW(BUF_AW), .DROP_W(DROP_W)) u_writer (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_last(rx_last), .done_q(done_q), .mem_we(mem_we), .mem_buf(mem_buf),
    .mem_byte(mem_byte), .mem_data(mem_data), .done_set(done_set),
    .drop_count(drop_count)
  );

  rxpp_status #(.NBUF(NBUF)) u_status (
    .clk(clk), .rst_n(rst_n), .done_set(done_set), .wr_en(stat_wr),
    .wr_buf(a_buf), .wr_done(bus_wdata[STAT_DONE_BIT]),
    .wr_ie(bus_wdata[STAT_IE_BIT]), .gie(irq_global_en),
    .done_q(done_q), .ie_q(ie_q), .irq(irq)
  );

  rxpp_ram #(.AW(RAM_AW)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(mem_we),
    .waddr(RAM_AW'({mem_buf, mem_byte[BUF_AW-1:2]})),
    .wlane(mem_byte[1:0]), .wbyte(mem_data),
    .re(bus_rd && buf_ok && !is_stat),
    .raddr(RAM_AW'({a_buf, a_word})), .rdata(ram_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_hit_q      <= 1'b0;
      rd_stat_q     <= 1'b0;
      rd_stat_val_q <= '0;
    end else if (bus_rd) begin
      rd_hit_q      <= buf_ok;
      rd_stat_q     <= is_stat;
      rd_stat_val_q <= stat_val;
    end
  end

  assign bus_rdata = !rd_hit_q ? '0 : (rd_stat_q ? rd_stat_val_q : ram_rdata);
endmodule

// File: rtl/rxpp_chk.sv
module rxpp_chk #(
  parameter int DUAL_BUF = 1,
  parameter int DROP_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic              rx_last,
  input logic              bus_wr,
  input logic              irq_global_en,
  input logic              irq,
  input logic [DROP_W-1:0] drop_count,
  input logic [1:0]        done_q
);
  AST_DONE0_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q[0]) |-> $past(rx_valid && rx_last)); // R4
  AST_DONE1_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q[1]) |-> $past(rx_valid && rx_last)); // R4
  AST_ONE_BUF_PER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !($rose(done_q[0]) && $rose(done_q[1]))); // R5
  AST_DONE0_CLR_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_q[0]) |-> $past(bus_wr)); // R6
  AST_DONE1_CLR_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_q[1]) |-> $past(bus_wr)); // R6
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_global_en); // R7
  AST_DROP_ON_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(drop_count) |-> $past(rx_valid)); // R8
  AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(drop_count) |-> (drop_count == DROP_W'($past(drop_count) + 1'b1))); // R8
  AST_SINGLE_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    (DUAL_BUF != 0) || !done_q[1]); // R10
endmodule

bind rx_pingpong_buf rxpp_chk #(.DUAL_BUF(DUAL_BUF), .DROP_W(DROP_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_last(rx_last),
  .bus_wr(bus_wr), .irq_global_en(irq_global_en), .irq(irq),
  .drop_count(drop_count), .done_q(done_q)
);

// File: tb/rx_pingpong_buf_tb_top.sv
module rx_pingpong_buf_tb_top;
  logic        clk, rst_n;
  logic        rx_valid, rx_last, rx1_valid, rx1_last;
  logic [7:0]  rx_data, rx1_data;
  logic [12:0] bus_addr;
  logic        bus_wr, bus_rd, gie;
  logic [31:0] bus_wdata, rdata0, rdata1;
  logic        irq0, irq1;
  logic [7:0]  drop0, drop1;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  logic [31:0] exp_q[$];
  bit          who_q[$];
  string       tag_q[$];
  logic        rd_pend;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  rx_pingpong_buf #(.DUAL_BUF(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_last(rx_last), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(rdata0),
    .irq_global_en(gie), .irq(irq0), .drop_count(drop0)
  );

  rx_pingpong_buf #(.DUAL_BUF(0)) dut1_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx1_valid), .rx_data(rx1_data),
    .rx_last(rx1_last), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(rdata1),
    .irq_global_en(gie), .irq(irq1), .drop_count(drop1)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_frame(input int len, input int seed, input bit to1);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (to1) begin
        rx1_valid = 1'b1; rx1_data = 8'(seed + i); rx1_last = (i == len - 1);
      end else begin
        rx_valid = 1'b1; rx_data = 8'(seed + i); rx_last = (i == len - 1);
      end
    end
    @(negedge clk);
    if (to1) begin rx1_valid = 1'b0; rx1_last = 1'b0; end
    else begin rx_valid = 1'b0; rx_last = 1'b0; end
  endtask

  task automatic bus_write(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // driver: issue a read and push the expected word into the scoreboard
  task automatic expect_rd(input logic [12:0] a, input logic [31:0] e,
                           input bit who, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); who_q.push_back(who); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  always @(posedge clk) rd_pend <= bus_rd;

  // monitor: compare returned read data against the scoreboard
  always @(negedge clk) begin
    if (rd_pend === 1'b1 && exp_q.size() > 0) begin
      logic [31:0] e;
      bit w;
      string t;
      e = exp_q.pop_front(); w = who_q.pop_front(); t = tag_q.pop_front();
      chk(w ? rdata1 : rdata0, e, t);
    end
  end

  task automatic report();
    if (!done_flag) begin
      done_flag = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end

  initial begin
    rst_n = 1'b0; rx_valid = 0; rx_last = 0; rx_data = 0;
    rx1_valid = 0; rx1_last = 0; rx1_data = 0;
    bus_addr = 0; bus_wr = 0; bus_rd = 0; bus_wdata = 0; gie = 1'b1;
    rd_pend = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(32'(irq0), 0, "R1 irq after reset");
    chk(32'(drop0), 0, "R1 drop count after reset");
    expect_rd(13'h17FC, 32'h0, 0, "R1 status0 after reset");
    expect_rd(13'h1FFC, 32'h0, 0, "R1 status1 after reset");
    expect_rd(13'h0000, 32'h0, 0, "R2 read below window");

    bus_write(13'h17FC, 32'h8);
    bus_write(13'h1FFC, 32'h8);
    expect_rd(13'h17FC, 32'h8, 0, "R6 ie0 loaded");

    send_frame(16, 'h10, 0);
    expect_rd(13'h17FC, 32'h9, 0, "R4 done0 set");
    expect_rd(13'h1000, 32'h13121110, 0, "R3 word0 byte order");
    expect_rd(13'h100C, 32'h1F1E1D1C, 0, "R3 type field word");
    chk(32'(irq0), 1, "R7 irq with done0 and ie0");

    send_frame(8, 'h40, 0);
    expect_rd(13'h1FFC, 32'h9, 0, "R5 second frame in buffer1");
    expect_rd(13'h1800, 32'h43424140, 0, "R5 buffer1 word0");
    expect_rd(13'h1804, 32'h47464544, 0, "R5 buffer1 word1");

    @(negedge clk); gie = 1'b0;
    @(negedge clk); chk(32'(irq0), 0, "R7 irq masked by global enable");
    gie = 1'b1;

    send_frame(8, 'h80, 0);
    @(negedge clk);
    chk(32'(drop0), 1, "R8 drop counted");
    expect_rd(13'h1000, 32'h13121110, 0, "R8 buffer0 untouched");
    expect_rd(13'h17FC, 32'h9, 0, "R8 status0 unchanged");

    bus_write(13'h17FC, 32'h9);
    expect_rd(13'h17FC, 32'h9, 0, "R6 writing one keeps done");
    bus_write(13'h17FC, 32'h8);
    expect_rd(13'h17FC, 32'h8, 0, "R6 writing zero clears done");
    @(negedge clk); chk(32'(irq0), 1, "R7 irq from buffer1");
    bus_write(13'h1FFC, 32'h0);
    expect_rd(13'h1FFC, 32'h0, 0, "R6 clear done1 and ie1");
    @(negedge clk); chk(32'(irq0), 0, "R7 irq low with no enabled done");

    send_frame(4, 'hA0, 0);
    expect_rd(13'h1000, 32'hA3A2A1A0, 0, "R8 turn kept after drop");
    expect_rd(13'h17FC, 32'h9, 0, "R8 buffer0 done again");

    send_frame(4, 'hB0, 0);
    fork
      send_frame(4, 'hD0, 0);
      bus_write(13'h17FC, 32'h8);
    join
    @(negedge clk);
    chk(32'(drop0), 2, "R11 same-cycle clear still drops");
    expect_rd(13'h17FC, 32'h8, 0, "R11 status0 cleared");
    expect_rd(13'h1000, 32'hA3A2A1A0, 0, "R11 buffer0 untouched");
    send_frame(4, 'hC0, 0);
    expect_rd(13'h1000, 32'hC3C2C1C0, 0, "R11 next frame lands in buffer0");

    bus_write(13'h1FFC, 32'h8);
    send_frame(2050, 0, 0);
    expect_rd(13'h1FFC, 32'h9, 0, "R9 truncated frame marked done");
    expect_rd(13'h1FF8, 32'hFBFAF9F8, 0, "R9 last stored word");
    expect_rd(13'h1800, 32'h03020100, 0, "R9 no wrap to buffer start");

    send_frame(4, 'h11, 1);
    expect_rd(13'h1000, 32'h14131211, 1, "R10 single mode frame1");
    expect_rd(13'h17FC, 32'h9, 1, "R10 single mode done0");
    bus_write(13'h17FC, 32'h8);
    send_frame(4, 'h21, 1);
    expect_rd(13'h1000, 32'h24232221, 1, "R10 single mode frame2 in buffer0");
    expect_rd(13'h1800, 32'h0, 1, "R10 buffer1 window reads zero");
    expect_rd(13'h1FFC, 32'h0, 1, "R10 status1 reads zero");
    @(negedge clk);
    chk(32'(drop1), 0, "R10 no drops in single mode");

    repeat (3) @(negedge clk);
    report();
  end
endmodule